// File: doc/BRIEF.md
# UART Receive Status Controller

This block holds the receive-side status of a UART. It takes completed characters from the receive shifter, each with framing-error and noise indications, and places them either in a small receive FIFO or in a single holding register. It keeps a data-ready indication, three sticky error flags (framing, noise, overrun), an error interrupt and a receive DMA request. Software reads a character with a read strobe and clears each error flag with its own one-cycle clear strobe.

Two static settings shape its behaviour. The first is overrun-disable. When it is off, characters go through the FIFO, and a character that finds the FIFO full raises overrun. When it is on, the FIFO is bypassed: every character overwrites the holding register and overrun never rises. The second is the error policy. Under policy 0, a bad character only raises its error flag and is dropped. Under policy 1, a bad character is stored and marked ready, and the DMA request is held off until every error flag is clear. Both settings are locked while the UART enable is high.

The DMA request passes through a four-state gate classifier:
- GATE_OFF: DMA receive disabled.
- GATE_IDLE: nothing ready.
- GATE_MASKED: data ready but held off by an error under policy 1.
- GATE_REQ: request asserted.

The classifier moves between these states with no delay as its inputs change. The configuration side has two conditions: open, when the UART enable is low, and locked, when it is high.

Top module: `uart_rx_status_ctrl`

## Requirements
- R1: `err_irq` is 1 exactly when `err_irq_en` is 1 and at least one of `flag_fe`, `flag_ne`, `flag_ore` is 1.
- R2: With `ovr_dis_q`=0, a stored character that arrives while the FIFO holds FIFO_DEPTH entries sets `flag_ore` on the next edge and is discarded. Characters already queued stay intact and in order.
- R3: With `ovr_dis_q`=1, `flag_ore` never rises. Each stored character overwrites the holding register, `rd_data` shows the newest character and `rxne` is 1, even if earlier characters were never read.
- R4: With `err_policy_q`=0, a character with `rx_fe` or `rx_ne` set raises the matching flag but is not stored and leaves `rxne` unchanged. The next good character is stored and requested normally.
- R5: With `err_policy_q`=1, a character with an error is stored and sets `rxne` together with its error flag. `dma_req` stays 0 while any error flag is 1.
- R6: `dma_req` = `dma_rx_en` AND `rxne` AND NOT (`err_policy_q` AND any error flag).
- R7: `cfg_we` updates `ovr_dis_q` from `cfg_ovr_dis` and `err_policy_q` from `cfg_err_policy` only in a cycle where `uart_en` is 0. At other times the write is ignored.
- R8: Each error flag is set on the edge after its set event and cleared on the edge after its clear strobe. When both occur in the same cycle, the flag ends up 1.
- R9: `rd_strobe` removes the oldest FIFO entry (FIFO mode) or clears the holding-register ready bit (bypass mode). `rd_data` presents characters in arrival order. A new character arriving in the same cycle as a bypass read leaves `rxne` at 1.
- R10: After reset, `rxne`, all flags, `err_irq`, `dma_req`, `ovr_dis_q` and `err_policy_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | UART enable; 1 locks the configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ovr_dis | input | 1 | New overrun-disable value (1 = detection off, FIFO bypassed) |
| cfg_err_policy | input | 1 | New error policy (0 = drop bad char, 1 = store and mask DMA) |
| err_irq_en | input | 1 | Error interrupt enable |
| dma_rx_en | input | 1 | Receive DMA enable |
| rx_valid | input | 1 | One-cycle strobe: a character completed |
| rx_data | input | DATA_W | Completed character |
| rx_fe | input | 1 | Framing error on this character |
| rx_ne | input | 1 | Noise detected on this character |
| rd_strobe | input | 1 | Software or DMA read of the data register |
| clr_fe | input | 1 | Clear strobe for the framing flag |
| clr_ne | input | 1 | Clear strobe for the noise flag |
| clr_ore | input | 1 | Clear strobe for the overrun flag |
| rd_data | output | DATA_W | Oldest FIFO entry, or holding register in bypass mode |
| rxne | output | 1 | Data ready |
| flag_fe | output | 1 | Framing error flag |
| flag_ne | output | 1 | Noise flag |
| flag_ore | output | 1 | Overrun flag |
| ovr_dis_q | output | 1 | Current overrun-disable setting |
| err_policy_q | output | 1 | Current error policy |
| err_irq | output | 1 | Error interrupt |
| dma_req | output | 1 | Receive DMA request |

## Verification
The bench builds the block with DATA_W=8 and FIFO_DEPTH=4. Four stored characters therefore fill the FIFO, and the fifth triggers overrun, which makes the full-queue discard and the in-order drain after it reachable in a short vector table. The 8-bit data width lets each character carry a distinct tag, so the bench can check FIFO order, the newest-wins overwrite in bypass mode and the policy-0 drop by value.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    localparam int FLAG_N   = 3;
    localparam int FLAG_FE  = 0;
    localparam int FLAG_NE  = 1;
    localparam int FLAG_ORE = 2;

    typedef enum logic [1:0] {
        GATE_OFF,
        GATE_IDLE,
        GATE_REQ,
        GATE_MASKED
    } dma_gate_e;

endpackage

// File: rtl/rxs_cfg.sv
module rxs_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic uart_en,
    input  logic cfg_we,
    input  logic ovr_dis_in,
    input  logic policy_in,
    output logic ovr_dis_q,
    output logic policy_q
);

    logic wr_open;

    assign wr_open = cfg_we && !uart_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_dis_q <= 1'b0;
            policy_q  <= 1'b0;
        end else if (wr_open) begin
            ovr_dis_q <= ovr_dis_in;
            policy_q  <= policy_in;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        uart_en |=> ($stable(ovr_dis_q) && $stable(policy_q))); // R7

endmodule

// File: rtl/rxs_flags.sv
module rxs_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_ev,
    output logic [N-1:0] flag_q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_ev[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flag_q[i]); // R8
    end

endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CNT_FULL);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9

endmodule

// File: rtl/rxs_dma_gate.sv
module rxs_dma_gate
    import rxs_pkg::*;
(
    input  logic      dma_en,
    input  logic      rxne,
    input  logic      mask,
    output dma_gate_e gate_st,
    output logic      dma_req
);

    always_comb begin
        if (!dma_en) begin
            gate_st = GATE_OFF;
        end else if (!rxne) begin
            gate_st = GATE_IDLE;
        end else if (mask) begin
            gate_st = GATE_MASKED;
        end else begin
            gate_st = GATE_REQ;
        end
    end

    always_comb begin
        unique case (gate_st)
            GATE_OFF:    dma_req = 1'b0;
            GATE_IDLE:   dma_req = 1'b0;
            GATE_MASKED: dma_req = 1'b0;
            GATE_REQ:    dma_req = 1'b1;
            default:     dma_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
    import rxs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_en,
    input  logic              cfg_we,
    input  logic              cfg_ovr_dis,
    input  logic              cfg_err_policy,
    input  logic              err_irq_en,
    input  logic              dma_rx_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_fe,
    input  logic              rx_ne,
    input  logic              rd_strobe,
    input  logic              clr_fe,
    input  logic              clr_ne,
    input  logic              clr_ore,
    output logic [DATA_W-1:0] rd_data,
    output logic              rxne,
    output logic              flag_fe,
    output logic              flag_ne,
    output logic              flag_ore,
    output logic              ovr_dis_q,
    output logic              err_policy_q,
    output logic              err_irq,
    output logic              dma_req
);

    logic              char_bad;
    logic              char_store;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_empty;
    logic              fifo_full;
    logic [DATA_W-1:0] fifo_dout;
    logic              overrun_ev;
    logic              hold_wr;
    logic              hold_v;
    logic [DATA_W-1:0] hold_q;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_vec;
    logic [FLAG_N-1:0] flag_vec;
    logic              any_err;
    logic              dma_mask;
    dma_gate_e         gate_st;

    rxs_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .uart_en    (uart_en),
        .cfg_we     (cfg_we),
        .ovr_dis_in (cfg_ovr_dis),
        .policy_in  (cfg_err_policy),
        .ovr_dis_q  (ovr_dis_q),
        .policy_q   (err_policy_q)
    );

    // A bad character survives only under the store-and-mask policy.
    assign char_bad   = rx_fe || rx_ne;
    assign char_store = rx_valid && (!char_bad || err_policy_q);

    // Queue path (overrun detection on) versus overwrite path (bypass).
    assign fifo_push  = char_store && !ovr_dis_q && !fifo_full;
    assign overrun_ev = char_store && !ovr_dis_q && fifo_full;
    assign fifo_pop   = rd_strobe && !ovr_dis_q && !fifo_empty;
    assign hold_wr    = char_store && ovr_dis_q;

    rxs_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (rx_data),
        .dout  (fifo_dout),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_q <= '0;
        end else if (hold_wr) begin
            hold_v <= 1'b1;
            hold_q <= rx_data;
        end else if (rd_strobe && ovr_dis_q) begin
            hold_v <= 1'b0;
        end
    end

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_FE]  = rx_valid && rx_fe;
        set_vec[FLAG_NE]  = rx_valid && rx_ne;
        set_vec[FLAG_ORE] = overrun_ev;
        clr_vec           = '0;
        clr_vec[FLAG_FE]  = clr_fe;
        clr_vec[FLAG_NE]  = clr_ne;
        clr_vec[FLAG_ORE] = clr_ore;
    end

    rxs_flags #(
        .N (FLAG_N)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_vec),
        .clr_ev (clr_vec),
        .flag_q (flag_vec)
    );

    assign flag_fe  = flag_vec[FLAG_FE];
    assign flag_ne  = flag_vec[FLAG_NE];
    assign flag_ore = flag_vec[FLAG_ORE];
    assign any_err  = |flag_vec;
    assign err_irq  = err_irq_en && any_err;
    assign dma_mask = err_policy_q && any_err;

    assign rxne    = ovr_dis_q ? hold_v : !fifo_empty;
    assign rd_data = ovr_dis_q ? hold_q : fifo_dout;

    rxs_dma_gate u_gate (
        .dma_en  (dma_rx_en),
        .rxne    (rxne),
        .mask    (dma_mask),
        .gate_st (gate_st),
        .dma_req (dma_req)
    );

    AST_ORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_dis_q && !flag_ore) |=> !flag_ore); // R3
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_policy_q && (flag_fe || flag_ne || flag_ore)) |-> !dma_req); // R5
    AST_POLICY0_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && (rx_fe || rx_ne) && !err_policy_q && !rd_strobe && !cfg_we)
        |=> $stable(rxne)); // R4
    AST_REQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (gate_st == GATE_REQ && rxne && dma_rx_en)); // R6

endmodule

// File: tb/sim_uart_rx_status_ctrl.sv
`timescale 1ns/1ps
module sim_uart_rx_status_ctrl;

    localparam int DW = 8;
    localparam int DEPTH = 4;
    localparam int NV = 17;

    typedef struct packed {
        logic [7:0] d;
        logic [6:0] ctl;   // valid fe ne rd clr_fe clr_ne clr_ore
        logic [7:0] xd;
        logic [5:0] xp;    // rxne fe ne ore dma irq
    } vec_t;

    localparam vec_t TBL [NV] = '{
        '{8'h11, 7'b1000000, 8'h11, 6'b100010},
        '{8'h22, 7'b1000000, 8'h11, 6'b100010},
        '{8'h00, 7'b0001000, 8'h22, 6'b100010},
        '{8'h00, 7'b0001000, 8'h00, 6'b000000},
        '{8'h33, 7'b1100000, 8'h33, 6'b110001},
        '{8'h00, 7'b0000100, 8'h33, 6'b100010},
        '{8'h44, 7'b1011000, 8'h44, 6'b101001},
        '{8'h55, 7'b1010010, 8'h44, 6'b101001},
        '{8'h00, 7'b0000010, 8'h44, 6'b100010},
        '{8'h66, 7'b1000000, 8'h44, 6'b100010},
        '{8'h77, 7'b1000000, 8'h44, 6'b100010},
        '{8'h88, 7'b1000000, 8'h44, 6'b100101},
        '{8'h00, 7'b0001000, 8'h55, 6'b100101},
        '{8'h00, 7'b0000001, 8'h55, 6'b100010},
        '{8'h00, 7'b0001000, 8'h66, 6'b100010},
        '{8'h00, 7'b0001000, 8'h77, 6'b100010},
        '{8'h00, 7'b0001000, 8'h00, 6'b000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uart_en = 1'b0, cfg_we = 1'b0, cfg_ovr_dis = 1'b0, cfg_err_policy = 1'b0;
    logic err_irq_en = 1'b0, dma_rx_en = 1'b0;
    logic rx_valid = 1'b0, rx_fe = 1'b0, rx_ne = 1'b0, rd_strobe = 1'b0;
    logic clr_fe = 1'b0, clr_ne = 1'b0, clr_ore = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic [DW-1:0] rd_data;
    logic rxne, flag_fe, flag_ne, flag_ore, ovr_dis_q, err_policy_q, err_irq, dma_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_rx_status_ctrl #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .cfg_we(cfg_we),
        .cfg_ovr_dis(cfg_ovr_dis), .cfg_err_policy(cfg_err_policy),
        .err_irq_en(err_irq_en), .dma_rx_en(dma_rx_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_fe(rx_fe), .rx_ne(rx_ne), .rd_strobe(rd_strobe),
        .clr_fe(clr_fe), .clr_ne(clr_ne), .clr_ore(clr_ore), .rd_data(rd_data),
        .rxne(rxne), .flag_fe(flag_fe), .flag_ne(flag_ne), .flag_ore(flag_ore),
        .ovr_dis_q(ovr_dis_q), .err_policy_q(err_policy_q), .err_irq(err_irq),
        .dma_req(dma_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [7:0] d, input logic [6:0] ctl);
        @(negedge clk);
        rx_data   = d;
        rx_valid  = ctl[6];
        rx_fe     = ctl[5];
        rx_ne     = ctl[4];
        rd_strobe = ctl[3];
        clr_fe    = ctl[2];
        clr_ne    = ctl[1];
        clr_ore   = ctl[0];
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rx_fe = 1'b0; rx_ne = 1'b0; rd_strobe = 1'b0;
        clr_fe = 1'b0; clr_ne = 1'b0; clr_ore = 1'b0;
        #1;
    endtask

    task automatic cfg_write(input logic ovr, input logic pol);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ovr_dis = ovr; cfg_err_policy = pol;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 rxne", rxne, 0);
        check("R10 flags", {flag_fe, flag_ne, flag_ore}, 0);
        check("R10 irq/dma", {err_irq, dma_req}, 0);
        check("R10 cfg", {ovr_dis_q, err_policy_q}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // FIFO mode, policy 1, interrupts and DMA on
        cfg_write(1'b0, 1'b1);
        check("R7 open write", {ovr_dis_q, err_policy_q}, 2'b01);
        @(negedge clk);
        uart_en = 1'b1; err_irq_en = 1'b1; dma_rx_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].d, TBL[i].ctl);
            check($sformatf("R9 rxne vec%0d", i), rxne, TBL[i].xp[5]);
            check($sformatf("R5_R8 fe vec%0d", i), flag_fe, TBL[i].xp[4]);
            check($sformatf("R5_R8 ne vec%0d", i), flag_ne, TBL[i].xp[3]);
            check($sformatf("R2 ore vec%0d", i), flag_ore, TBL[i].xp[2]);
            check($sformatf("R6 dma vec%0d", i), dma_req, TBL[i].xp[1]);
            check($sformatf("R1 irq vec%0d", i), err_irq, TBL[i].xp[0]);
            if (TBL[i].xp[5]) begin
                check($sformatf("R9 data vec%0d", i), rd_data, TBL[i].xd);
            end
        end

        // R7: write while enabled is ignored
        cfg_write(1'b1, 1'b0);
        check("R7 locked write", {ovr_dis_q, err_policy_q}, 2'b01);

        // R4: policy 0 drops bad characters
        @(negedge clk); uart_en = 1'b0;
        cfg_write(1'b0, 1'b0);
        check("R7 reopened write", {ovr_dis_q, err_policy_q}, 2'b00);
        @(negedge clk); uart_en = 1'b1;
        step(8'hB1, 7'b1100000);
        check("R4 fe set", flag_fe, 1);
        check("R4 no store", rxne, 0);
        check("R4 no dma", dma_req, 0);
        step(8'hB2, 7'b1000000);
        check("R4 next good stored", rxne, 1);
        check("R4 next good data", rd_data, 8'hB2);
        check("R6 policy0 unmasked", dma_req, 1);
        step(8'h00, 7'b0000100);
        check("R8 fe cleared", flag_fe, 0);
        step(8'h00, 7'b0001000);
        check("R9 drained", rxne, 0);

        // R1: interrupt inhibited by enable
        @(negedge clk); err_irq_en = 1'b0;
        step(8'hC0, 7'b1010000);
        check("R1 ne set", flag_ne, 1);
        check("R1 irq inhibited", err_irq, 0);
        @(negedge clk); err_irq_en = 1'b1; #1;
        check("R1 irq enabled", err_irq, 1);
        step(8'h00, 7'b0000010);
        check("R1 irq after clear", err_irq, 0);

        // R6: DMA enable gates the request
        @(negedge clk); dma_rx_en = 1'b0;
        step(8'hC1, 7'b1000000);
        check("R6 rxne", rxne, 1);
        check("R6 dma off", dma_req, 0);
        @(negedge clk); dma_rx_en = 1'b1; #1;
        check("R6 dma on", dma_req, 1);
        step(8'h00, 7'b0001000);
        check("R6 empty no dma", dma_req, 0);

        // R3: overrun-disable bypass with overwrite
        @(negedge clk); uart_en = 1'b0;
        cfg_write(1'b1, 1'b0);
        check("R3 cfg", ovr_dis_q, 1);
        @(negedge clk); uart_en = 1'b1;
        step(8'hD1, 7'b1000000);
        step(8'hD2, 7'b1000000);
        check("R3 no ore", flag_ore, 0);
        check("R3 overwrite", rd_data, 8'hD2);
        check("R3 rxne", rxne, 1);
        for (int k = 0; k < 5; k++) begin
            step(8'hD3 + 8'(k), 7'b1000000);
        end
        check("R3 no ore past depth", flag_ore, 0);
        check("R3 newest", rd_data, 8'hD7);
        step(8'hD8, 7'b1001000);
        check("R9 set wins over read", rxne, 1);
        check("R9 read-write data", rd_data, 8'hD8);
        step(8'h00, 7'b0001000);
        check("R9 bypass read clears", rxne, 0);

        finish_run();
    end

endmodule